// File: doc/BRIEF.md
# DMA Channel Enable Register File

This block holds the per-channel control state of a 16-channel DMA engine: a request-enable vector that lets each channel accept hardware requests, and an error-interrupt-enable vector that decides which channel errors reach the interrupt controller. Both vectors are reachable through a simple register bus with address, write strobe, write data, read strobe and registered read data.

Software can enable one channel's requests without a read-modify-write cycle. It writes a channel index to a write-only command byte. One command bit switches on all channels at once. Index values beyond the channel count are reserved and do nothing. The block also combines the per-channel error flags with the interrupt-enable vector and produces one registered error interrupt request.

Top module: `dma_enable_regs`

## Requirements
- R1: After reset, `req_en_o`, `err_irq_en_o`, `err_irq_o` and `rdata_o` are all zero.
- R2: Offset 0x14 holds the error-interrupt-enable vector. A write stores `wdata_i[15:0]`, with channel n at bit n. A read returns that vector in bits [15:0] and zero in bits [31:16].
- R3: Offset 0x0C holds the request-enable vector. A write replaces the whole vector with `wdata_i[15:0]`. A read returns it in bits [15:0] and zero in bits [31:16].
- R4: A write to offset 0x18 carries a command value in `wdata_i[6:0]`. Bit 7 is reserved and ignored. A command value of 0 to 15 sets only the request-enable bit of that channel and leaves every other bit unchanged.
- R5: A set command with `wdata_i[6]` = 1 (values 64 to 127) sets all 16 request-enable bits.
- R6: Set command values 16 to 63 leave the request-enable vector unchanged. Bit 5 of the command has no effect of its own.
- R7: A read of offset 0x18 or of any unmapped offset returns zero. A write to an unmapped offset changes neither vector.
- R8: `err_irq_o` is high in the cycle after any channel has both its error flag and its interrupt-enable bit set. It stays high while such a channel exists and is low otherwise.
- R9: `rdata_o` carries the data of a read one cycle after `rd_i` is high. It is zero after a cycle with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Byte offset of the access |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| err_flag_i | input | 16 | Per-channel error flags |
| req_en_o | output | 16 | Request-enable vector |
| err_irq_en_o | output | 16 | Error-interrupt-enable vector |
| err_irq_o | output | 1 | Registered error interrupt request |

## Verification
The assertions assume that every input is a known value from the first clock after reset and that one bus access at most is presented per cycle. The set-command properties treat a write to 0x18 as a command and nothing else. The stimulus keeps within this: the bench changes all inputs on the falling clock edge, never issues a write and a read together, and drives every error flag to a defined level on every cycle. It steps through all 16 channel indices, the three reserved sub-ranges, the set-all range with and without bit 7, and error flags on both enabled and disabled channels.

// File: rtl/dma_en_pkg.sv
package dma_en_pkg;
  localparam int unsigned REQ_EN_OFS  = 'h0C;
  localparam int unsigned ERR_IE_OFS  = 'h14;
  localparam int unsigned SET_REQ_OFS = 'h18;

  typedef struct packed {
    logic req_en;
    logic err_ie;
    logic set_req;
  } reg_sel_t;
endpackage

// File: rtl/dma_en_addr_dec.sv
module dma_en_addr_dec
  import dma_en_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_t          sel_o
);
  always_comb begin
    sel_o         = '0;
    sel_o.req_en  = (addr_i == ADDR_W'(REQ_EN_OFS));
    sel_o.err_ie  = (addr_i == ADDR_W'(ERR_IE_OFS));
    sel_o.set_req = (addr_i == ADDR_W'(SET_REQ_OFS));
  end
endmodule

// File: rtl/dma_en_set_dec.sv
module dma_en_set_dec #(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned CMD_W  = 7
) (
  input  logic              valid_i,
  input  logic [CMD_W-1:0]  cmd_i,
  output logic [NUM_CH-1:0] set_mask_o
);
  localparam int unsigned IDX_W = CMD_W - 1;

  logic             all_set;
  logic [IDX_W-1:0] idx;

  assign all_set = cmd_i[CMD_W-1];
  assign idx     = cmd_i[IDX_W-1:0];

  // indices at or above NUM_CH match no channel, so the reserved range is a no-op
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign set_mask_o[ch] = valid_i & (all_set | (idx == IDX_W'(ch)));
  end
endmodule

// File: rtl/dma_en_irq_reduce.sv
module dma_en_irq_reduce #(
  parameter int unsigned NUM_CH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] flag_i,
  input  logic [NUM_CH-1:0] en_i,
  output logic              irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(flag_i & en_i);
  end
endmodule

// File: rtl/dma_enable_regs.sv
module dma_enable_regs
  import dma_en_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CMD_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_CH-1:0] err_flag_i,
  output logic [NUM_CH-1:0] req_en_o,
  output logic [NUM_CH-1:0] err_irq_en_o,
  output logic              err_irq_o
);
  reg_sel_t          sel;
  logic [NUM_CH-1:0] req_en_q, err_ie_q, set_mask, req_en_d;
  logic [DATA_W-1:0] rd_val;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:NUM_CH];

  dma_en_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  dma_en_set_dec #(.NUM_CH(NUM_CH), .CMD_W(CMD_W)) u_set (
    .valid_i    (wr_i & sel.set_req),
    .cmd_i      (wdata_i[CMD_W-1:0]),
    .set_mask_o (set_mask)
  );

  // direct write first, set command OR-ed on top
  always_comb begin
    req_en_d = req_en_q;
    if (wr_i && sel.req_en) req_en_d = wdata_i[NUM_CH-1:0];
    req_en_d = req_en_d | set_mask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_en_q <= '0;
      err_ie_q <= '0;
    end else begin
      req_en_q <= req_en_d;
      if (wr_i && sel.err_ie) err_ie_q <= wdata_i[NUM_CH-1:0];
    end
  end

  always_comb begin
    rd_val = '0;
    if (sel.req_en)      rd_val = DATA_W'(req_en_q);
    else if (sel.err_ie) rd_val = DATA_W'(err_ie_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_val;
    else           rdata_o <= '0;
  end

  dma_en_irq_reduce #(.NUM_CH(NUM_CH)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flag_i (err_flag_i),
    .en_i   (err_ie_q),
    .irq_o  (err_irq_o)
  );

  assign req_en_o     = req_en_q;
  assign err_irq_en_o = err_ie_q;
endmodule

// File: rtl/dma_enable_regs_chk.sv
module dma_enable_regs_chk
  import dma_en_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [NUM_CH-1:0] err_flag_i,
  input logic [NUM_CH-1:0] req_en_o,
  input logic [NUM_CH-1:0] err_irq_en_o,
  input logic              err_irq_o
);
  logic set_wr, unmapped_wr;

  assign set_wr      = wr_i && (addr_i == ADDR_W'(SET_REQ_OFS));
  assign unmapped_wr = wr_i && (addr_i != ADDR_W'(SET_REQ_OFS))
                            && (addr_i != ADDR_W'(REQ_EN_OFS))
                            && (addr_i != ADDR_W'(ERR_IE_OFS));

  a_r4_set_never_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_wr |=> ((req_en_o & $past(req_en_o)) == $past(req_en_o)));

  a_r5_set_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_wr && wdata_i[6]) |=> (&req_en_o));

  a_r6_reserved_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_wr && !wdata_i[6] && (wdata_i[5:4] != 2'b00)) |=> $stable(req_en_o));

  a_r7_unmapped_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped_wr |=> ($stable(req_en_o) && $stable(err_irq_en_o)));

  a_r8_irq_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_o == $past(|(err_flag_i & err_irq_en_o)));

  a_r9_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> (rdata_o == '0));
endmodule

bind dma_enable_regs dma_enable_regs_chk #(
  .NUM_CH (NUM_CH),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .addr_i       (addr_i),
  .wr_i         (wr_i),
  .wdata_i      (wdata_i),
  .rd_i         (rd_i),
  .rdata_o      (rdata_o),
  .err_flag_i   (err_flag_i),
  .req_en_o     (req_en_o),
  .err_irq_en_o (err_irq_en_o),
  .err_irq_o    (err_irq_o)
);

// File: tb/dma_enable_regs_bench.sv
`timescale 1ns/1ps
module dma_enable_regs_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        wr_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        rd_i = 1'b0;
  logic [31:0] rdata_o;
  logic [15:0] err_flag_i = '0;
  logic [15:0] req_en_o;
  logic [15:0] err_irq_en_o;
  logic        err_irq_o;

  int vectors = 0;
  int miscompares = 0;

  int unsigned m_req = 0, m_ie = 0, m_rdata = 0;
  bit m_irq = 0;

  always #2.5 clk_i = ~clk_i;

  dma_enable_regs u_dma_enable_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rd_i(rd_i), .rdata_o(rdata_o),
    .err_flag_i(err_flag_i), .req_en_o(req_en_o),
    .err_irq_en_o(err_irq_en_o), .err_irq_o(err_irq_o)
  );

  task automatic compare(string tag);
    vectors++;
    if (req_en_o !== m_req[15:0]) begin
      miscompares++;
      $display("FAIL %s req_en_o actual %h expected %h", tag, req_en_o, m_req[15:0]);
    end
    if (err_irq_en_o !== m_ie[15:0]) begin
      miscompares++;
      $display("FAIL %s err_irq_en_o actual %h expected %h", tag, err_irq_en_o, m_ie[15:0]);
    end
    if (err_irq_o !== m_irq) begin
      miscompares++;
      $display("FAIL %s err_irq_o actual %b expected %b", tag, err_irq_o, m_irq);
    end
    if (rdata_o !== m_rdata) begin
      miscompares++;
      $display("FAIL %s rdata_o actual %h expected %h", tag, rdata_o, m_rdata);
    end
  endtask

  // reference: evaluate with the values present before the edge
  task automatic model_edge();
    int unsigned nreq, nie, nrd, cmd;
    bit nirq;
    nreq = m_req; nie = m_ie; nrd = 0;
    nirq = ((err_flag_i & m_ie[15:0]) != 0);
    if (rd_i) begin
      if (addr_i == 8'h0C)      nrd = m_req;
      else if (addr_i == 8'h14) nrd = m_ie;
    end
    if (wr_i) begin
      if (addr_i == 8'h0C) nreq = wdata_i & 32'hFFFF;
      if (addr_i == 8'h14) nie  = wdata_i & 32'hFFFF;
      if (addr_i == 8'h18) begin
        cmd = wdata_i & 32'h7F;
        if (cmd >= 64)      nreq = 32'hFFFF;
        else if (cmd < 16)  nreq = nreq | (32'd1 << cmd);
      end
    end
    m_req = nreq; m_ie = nie; m_rdata = nrd; m_irq = nirq;
  endtask

  task automatic cyc(input logic [7:0] a, input logic w, input logic [31:0] d,
                     input logic r, input logic [15:0] f, input string tag);
    addr_i = a; wr_i = w; wdata_i = d; rd_i = r; err_flag_i = f;
    @(posedge clk_i);
    model_edge();
    #1;
    compare(tag);
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    cyc(a, 1'b1, d, 1'b0, err_flag_i, tag);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    cyc(a, 1'b0, 32'h0, 1'b1, err_flag_i, tag);
  endtask

  task automatic idle(input logic [15:0] f, input string tag);
    cyc(8'h00, 1'b0, 32'h0, 1'b0, f, tag);
  endtask

  initial begin
    #(5.0 * 100000);
    miscompares++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    err_flag_i = 16'hFFFF;
    repeat (3) @(posedge clk_i);
    #1 compare("R1 reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle(16'h0000, "R1 after release");
    rd(8'h0C, "R9 read after reset");
    idle(16'h0000, "R9 idle zero");

    wr(8'h14, 32'hABCD_1234, "R2 ie write");
    rd(8'h14, "R2 ie read");
    wr(8'h0C, 32'hFFFF_00F0, "R3 req write");
    rd(8'h0C, "R3 req read");

    wr(8'h18, 32'h0000_0003, "R4 set ch3");
    wr(8'h18, 32'h0000_008F, "R4 bit7 ignored ch15");
    rd(8'h0C, "R4 readback");
    wr(8'h18, 32'h0000_0010, "R6 reserved 16");
    wr(8'h18, 32'h0000_002A, "R6 reserved 42");
    wr(8'h18, 32'h0000_003F, "R6 reserved 63");
    wr(8'h18, 32'h0000_0020, "R6 bit5 alone");
    rd(8'h0C, "R6 readback");
    rd(8'h18, "R7 cmd reads zero");
    wr(8'h20, 32'hFFFF_FFFF, "R7 unmapped write");
    wr(8'h10, 32'hFFFF_FFFF, "R7 unmapped write 2");
    rd(8'h04, "R7 unmapped read");

    wr(8'h0C, 32'h0, "R3 clear");
    for (int i = 0; i < 16; i++) begin
      wr(8'h18, 32'(i), "R4 walk index");
    end
    rd(8'h0C, "R4 walk readback");
    wr(8'h0C, 32'h0, "R3 clear");
    wr(8'h18, 32'h0000_0040, "R5 set all 64");
    wr(8'h0C, 32'h0000_0001, "R3 replace");
    wr(8'h18, 32'h0000_00FF, "R5 set all 127 bit7");
    wr(8'h0C, 32'h0, "R3 clear");
    wr(8'h18, 32'h0000_0055, "R5 set all 85");
    rd(8'h0C, "R5 readback");

    idle(16'h0001, "R8 disabled flag");
    idle(16'h0004, "R8 enabled flag");
    idle(16'h0004, "R8 held");
    idle(16'hEDCB, "R8 only disabled flags");
    idle(16'h0000, "R8 drop");
    wr(8'h14, 32'h0000_8000, "R2 ie ch15");
    idle(16'h8000, "R8 ch15 enabled");
    for (int i = 0; i < 16; i++) begin
      wr(8'h14, 32'(1 << i), "R2 ie walk");
      idle(16'(1 << i), "R8 walk hit");
      idle(~16'(1 << i), "R8 walk miss");
    end
    wr(8'h14, 32'h0, "R2 ie clear");
    idle(16'hFFFF, "R8 all disabled");
    idle(16'h0000, "R8 settle");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule